// File: doc/BRIEF.md
# Masked Multi-Channel Conversion Scan Sequencer

This block runs an analog-to-digital converter through one complete scan each time it is triggered. The channels taken in a scan are those set in a scan mask and not set in a reserved mask. The block samples both masks when the trigger is taken. A scan powers the converter up and lets it settle for a fixed number of clocks. It then converts the selected channels one after another, from the lowest index upward. For each channel it selects the channel in single-conversion mode, pulses start, polls for end-of-conversion, and polls again until the converter reports that channel as the sampled one. Only then does it store the 10-bit code.

Both polls run at a programmable interval and are bounded. If either poll runs out, the whole scan is abandoned. An error pulse names the channel that failed, and the previously delivered results stay as they were. If every channel succeeds, a done pulse comes with a packed result word and the number of valid entries. The converter is powered down at the end of every scan, whether it succeeded or failed. A trigger that arrives while a scan is running is dropped and recorded in a sticky overrun flag.

Top module: `adc_scan_seq`

## Requirements
- R1: While reset is held, conv_pwr_o, conv_single_o, conv_start_o, scan_done_o, scan_err_o and overrun_o are 0, res_buf_o is all zero and res_count_o is 0.
- R2: The channels in a scan are scan_mask_i AND NOT rsvd_mask_i, sampled in the cycle the trigger is taken. Changing the masks during a scan has no effect on that scan. Conversions are started in strictly ascending channel order.
- R3: On success, entry k of res_buf_o (bits 10k+9 down to 10k) holds the code of the k-th converted channel, taken from conv_data_i. Entries at k and above the count are zero. res_count_o equals the number of channels in the scan.
- R4: The first conv_start_o of a scan comes exactly PWRUP_CYC+1 clocks (9 by default) after conv_pwr_o rises. Every start is a pulse one clock long. It is given only while the converter is powered, with conv_single_o high and conv_chan_o unchanged since the previous clock.
- R5: End-of-conversion is polled first in the clock after start and then every poll_gap_i+1 clocks, where poll_gap_i is sampled at the trigger. There are at most MAX_POLLS+1 polls (21), which spans 20 intervals. If conv_eoc_i is high at the last poll, the scan continues; if it is still low, the scan fails.
- R6: After end-of-conversion, the data is taken only at a poll where conv_smp_ch_i equals the requested channel. This wait has the same interval and bound as the end-of-conversion wait, and the scan fails if it runs out.
- R7: On a failure, scan_err_o pulses and err_chan_o shows the failing channel. No done pulse is given. res_buf_o and res_count_o keep their previous values, and no later channel is started.
- R8: conv_pwr_o is high from the clock after the trigger is taken until the scan ends. It is low in the cycle of the done or error pulse and whenever no scan is running.
- R9: A trigger whose channel set is empty gives a done pulse in the next clock, with res_count_o = 0 and res_buf_o all zero. The converter is not powered in that scan.
- R10: A trigger that arrives while a scan is running is ignored and sets overrun_o, which stays set until reset. A trigger in the same cycle as a done pulse starts a new scan and does not set overrun_o.
- R11: scan_done_o and scan_err_o are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_i | input | 1 | Scan request, sampled each clock |
| scan_mask_i | input | 8 | Channels requested for the scan |
| rsvd_mask_i | input | 8 | Channels never to be converted |
| poll_gap_i | input | 8 | Poll interval minus one, in clocks |
| conv_pwr_o | output | 1 | Converter power enable |
| conv_single_o | output | 1 | Single-conversion mode select |
| conv_chan_o | output | 3 | Channel select to converter |
| conv_start_o | output | 1 | Start-of-conversion pulse |
| conv_eoc_i | input | 1 | End-of-conversion status |
| conv_smp_ch_i | input | 3 | Channel the converter reports as sampled |
| conv_data_i | input | 10 | Conversion code |
| scan_done_o | output | 1 | Successful scan pulse |
| scan_err_o | output | 1 | Failed scan pulse |
| err_chan_o | output | 3 | Channel on which the last scan failed |
| res_buf_o | output | 80 | Packed results, entry k at bits 10k+9:10k |
| res_count_o | output | 4 | Number of valid entries |
| overrun_o | output | 1 | Sticky dropped-trigger flag |

## Verification
Two things can land in the same clock: the completion of one scan and the trigger for the next. The bench waits for the done pulse and raises the trigger in that same clock. It then checks that power rises at once and that overrun stays clear. A trigger placed in the middle of a scan must instead set overrun and leave power off after the running scan ends. The poll bound is also tested where the arrival of end-of-conversion coincides with the final poll: a latency that just meets the last poll must succeed, and one clock more must fail. This is judged at two poll intervals.

// File: rtl/adc_scan_pkg.sv
// Shared types for the conversion scan sequencer.
package adc_scan_pkg;

    // Scan controller states, in the order a channel passes through them
    typedef enum logic [2:0] {
        SQ_IDLE     = 3'd0,
        SQ_PWRUP    = 3'd1,
        SQ_SELECT   = 3'd2,
        SQ_START    = 3'd3,
        SQ_WAIT_EOC = 3'd4,
        SQ_WAIT_CH  = 3'd5
    } sq_state_t;

endpackage

// File: rtl/adc_scan_pick.sv
// Lowest-set-bit finder.
// Returns the lowest channel index, at or above from_i, whose bit is set in
// mask_i. found_o is low when no such channel exists. from_i is one bit wider
// than a channel index, so that "past the last channel" can be expressed.
// Purely combinational.
module adc_scan_pick #(
    parameter int N_CH = 8,
    parameter int CH_W = $clog2(N_CH)
) (
    input  logic [N_CH-1:0] mask_i,
    input  logic [CH_W:0]   from_i,
    output logic            found_o,
    output logic [CH_W-1:0] ch_o
);

    // Descending scan so that the lowest qualifying index is written last
    always_comb begin
        found_o = 1'b0;
        ch_o    = '0;
        for (int i = N_CH - 1; i >= 0; i--) begin
            if (mask_i[i] && (i >= int'(from_i))) begin
                found_o = 1'b1;
                ch_o    = CH_W'(i);
            end
        end
    end

endmodule

// File: rtl/adc_scan_poll.sv
// Bounded poll timer.
// While en_i is high it raises poll_o in the first clock and then every
// gap_i+1 clocks. last_o marks the poll numbered MAX_POLLS (counting from 0),
// so a wait spans at most MAX_POLLS intervals. clr_i restarts the timer and
// must be pulsed in the clock before each new wait begins.
// Assumes gap_i is held stable for the whole wait.
module adc_scan_poll #(
    parameter int GAP_W     = 8,
    parameter int MAX_POLLS = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic [GAP_W-1:0] gap_i,
    output logic             poll_o,
    output logic             last_o
);

    localparam int PC_W = $clog2(MAX_POLLS + 1);

    logic [GAP_W-1:0] gap_cnt_q;
    logic [PC_W-1:0]  polls_q;

    assign poll_o = en_i && (gap_cnt_q == '0);
    assign last_o = (polls_q == PC_W'(MAX_POLLS));

    // Interval counter and count of polls already made in this wait
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            gap_cnt_q <= '0;
            polls_q   <= '0;
        end else if (en_i) begin
            gap_cnt_q <= (gap_cnt_q == gap_i) ? '0 : gap_cnt_q + GAP_W'(1);
            if (poll_o && !last_o) begin
                polls_q <= polls_q + PC_W'(1);
            end
        end
    end

    // R5
    poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        polls_q <= PC_W'(MAX_POLLS));

    // R5
    poll_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && poll_o && !clr_i && (gap_i != '0)) |=> !poll_o);

endmodule

// File: rtl/adc_scan_pack.sv
// Result packer.
// Fills a working buffer in write order: the n-th write lands in slot n.
// On commit_i it copies the working buffer, including any write made in the
// same clock, to the delivered buffer together with the fill count. The
// delivered buffer never shows a partial scan. clear_i empties the working
// buffer and takes priority over a write in the same clock.
module adc_scan_pack #(
    parameter int N_CH   = 8,
    parameter int DATA_W = 10
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clear_i,
    input  logic                        wr_i,
    input  logic [DATA_W-1:0]           data_i,
    input  logic                        commit_i,
    output logic [N_CH*DATA_W-1:0]      buf_o,
    output logic [$clog2(N_CH+1)-1:0]   count_o
);

    localparam int CNT_W = $clog2(N_CH + 1);
    localparam int BUF_W = N_CH * DATA_W;

    logic [BUF_W-1:0] work_q, work_nxt, out_q;
    logic [CNT_W-1:0] fill_q, fill_nxt, cnt_q;

    // Next fill level of the working buffer
    always_comb begin
        if (clear_i)   fill_nxt = '0;
        else if (wr_i) fill_nxt = fill_q + CNT_W'(1);
        else           fill_nxt = fill_q;
    end

    // One slot update per entry: clear, write at the fill point, or hold
    for (genvar g = 0; g < N_CH; g++) begin : g_slot
        assign work_nxt[g*DATA_W +: DATA_W] =
            clear_i                            ? '0     :
            (wr_i && (fill_q == CNT_W'(g)))    ? data_i :
                                                 work_q[g*DATA_W +: DATA_W];
    end

    // Working state, plus the delivered copy taken at commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work_q <= '0;
            fill_q <= '0;
            out_q  <= '0;
            cnt_q  <= '0;
        end else begin
            work_q <= work_nxt;
            fill_q <= fill_nxt;
            if (commit_i) begin
                out_q <= work_nxt;
                cnt_q <= fill_nxt;
            end
        end
    end

    assign buf_o   = out_q;
    assign count_o = cnt_q;

    // R3
    slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !clear_i) |-> (fill_q < CNT_W'(N_CH)));

    // R7
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> ($stable(buf_o) && $stable(count_o)));

endmodule

// File: rtl/adc_scan_seq.sv
// Conversion scan sequencer (top).
// On a trigger it samples the channel set (scan mask minus reserved mask) and
// the poll interval. It powers the converter up, waits PWRUP_CYC clocks, then
// for each channel in ascending order: selects the channel in single mode,
// pulses start, polls for end-of-conversion, polls until the sampled channel
// matches, and stores the code. Any poll that runs out aborts the scan with an
// error pulse. Success delivers the packed buffer with a done pulse. Power is
// dropped as the scan ends either way.
// Assumes the converter clears its end-of-conversion flag on a start.
module adc_scan_seq #(
    parameter int N_CH      = 8,
    parameter int DATA_W    = 10,
    parameter int GAP_W     = 8,
    parameter int MAX_POLLS = 20,
    parameter int PWRUP_CYC = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         trig_i,
    input  logic [N_CH-1:0]              scan_mask_i,
    input  logic [N_CH-1:0]              rsvd_mask_i,
    input  logic [GAP_W-1:0]             poll_gap_i,
    output logic                         conv_pwr_o,
    output logic                         conv_single_o,
    output logic [$clog2(N_CH)-1:0]      conv_chan_o,
    output logic                         conv_start_o,
    input  logic                         conv_eoc_i,
    input  logic [$clog2(N_CH)-1:0]      conv_smp_ch_i,
    input  logic [DATA_W-1:0]            conv_data_i,
    output logic                         scan_done_o,
    output logic                         scan_err_o,
    output logic [$clog2(N_CH)-1:0]      err_chan_o,
    output logic [N_CH*DATA_W-1:0]       res_buf_o,
    output logic [$clog2(N_CH+1)-1:0]    res_count_o,
    output logic                         overrun_o
);

    import adc_scan_pkg::*;

    localparam int CH_W = $clog2(N_CH);
    localparam int WT_W = $clog2(PWRUP_CYC + 1);

    sq_state_t        st_q, st_nxt;
    logic [N_CH-1:0]  mask_q;
    logic [GAP_W-1:0] gap_q;
    logic [CH_W-1:0]  cur_q;
    logic [WT_W-1:0]  wait_q;
    logic             done_q, err_q, ovr_q;
    logic [CH_W-1:0]  err_ch_q;

    logic [N_CH-1:0]  eff_mask;
    logic             first_found, next_found;
    logic [CH_W-1:0]  first_ch, next_ch;
    logic             accept, wr, commit, fail, load_next, clr, poll_en;
    logic             poll_now, poll_last;

    assign eff_mask = scan_mask_i & ~rsvd_mask_i;

    // Lowest channel of the incoming set
    adc_scan_pick #(.N_CH(N_CH), .CH_W(CH_W)) u_pick_first (
        .mask_i  (eff_mask),
        .from_i  ('0),
        .found_o (first_found),
        .ch_o    (first_ch)
    );

    // Next channel of the sampled set above the current one
    adc_scan_pick #(.N_CH(N_CH), .CH_W(CH_W)) u_pick_next (
        .mask_i  (mask_q),
        .from_i  ({1'b0, cur_q} + (CH_W+1)'(1)),
        .found_o (next_found),
        .ch_o    (next_ch)
    );

    assign poll_en = (st_q == SQ_WAIT_EOC) || (st_q == SQ_WAIT_CH);

    adc_scan_poll #(.GAP_W(GAP_W), .MAX_POLLS(MAX_POLLS)) u_poll (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clr),
        .en_i   (poll_en),
        .gap_i  (gap_q),
        .poll_o (poll_now),
        .last_o (poll_last)
    );

    adc_scan_pack #(.N_CH(N_CH), .DATA_W(DATA_W)) u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (accept),
        .wr_i     (wr),
        .data_i   (conv_data_i),
        .commit_i (commit),
        .buf_o    (res_buf_o),
        .count_o  (res_count_o)
    );

    // Next state and the one-clock actions of each transition
    always_comb begin
        st_nxt    = st_q;
        accept    = 1'b0;
        wr        = 1'b0;
        commit    = 1'b0;
        fail      = 1'b0;
        load_next = 1'b0;
        case (st_q)
            SQ_IDLE: begin
                if (trig_i) begin
                    accept = 1'b1;
                    if (first_found) st_nxt = SQ_PWRUP;
                    else             commit = 1'b1;
                end
            end
            SQ_PWRUP: begin
                if (wait_q == WT_W'(PWRUP_CYC - 1)) st_nxt = SQ_SELECT;
            end
            SQ_SELECT: st_nxt = SQ_START;
            SQ_START:  st_nxt = SQ_WAIT_EOC;
            SQ_WAIT_EOC: begin
                if (poll_now) begin
                    if (conv_eoc_i) begin
                        st_nxt = SQ_WAIT_CH;
                    end else if (poll_last) begin
                        st_nxt = SQ_IDLE;
                        fail   = 1'b1;
                    end
                end
            end
            SQ_WAIT_CH: begin
                if (poll_now) begin
                    if (conv_smp_ch_i == cur_q) begin
                        wr = 1'b1;
                        if (next_found) begin
                            st_nxt    = SQ_SELECT;
                            load_next = 1'b1;
                        end else begin
                            st_nxt = SQ_IDLE;
                            commit = 1'b1;
                        end
                    end else if (poll_last) begin
                        st_nxt = SQ_IDLE;
                        fail   = 1'b1;
                    end
                end
            end
            default: st_nxt = SQ_IDLE;
        endcase
        clr = (st_nxt != st_q);
    end

    // State register and per-scan context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= SQ_IDLE;
            mask_q <= '0;
            gap_q  <= '0;
            cur_q  <= '0;
            wait_q <= '0;
        end else begin
            st_q <= st_nxt;
            if (accept) begin
                mask_q <= eff_mask;
                gap_q  <= poll_gap_i;
                cur_q  <= first_ch;
                wait_q <= '0;
            end else if (st_q == SQ_PWRUP) begin
                wait_q <= wait_q + WT_W'(1);
            end
            if (load_next) cur_q <= next_ch;
        end
    end

    // Completion pulses, failing channel and sticky overrun
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            err_ch_q <= '0;
            ovr_q    <= 1'b0;
        end else begin
            done_q <= commit;
            err_q  <= fail;
            if (fail) err_ch_q <= cur_q;
            if (trig_i && (st_q != SQ_IDLE)) ovr_q <= 1'b1;
        end
    end

    assign conv_pwr_o    = (st_q != SQ_IDLE);
    assign conv_single_o = (st_q == SQ_SELECT) || (st_q == SQ_START) ||
                           (st_q == SQ_WAIT_EOC) || (st_q == SQ_WAIT_CH);
    assign conv_start_o  = (st_q == SQ_START);
    assign conv_chan_o   = cur_q;
    assign scan_done_o   = done_q;
    assign scan_err_o    = err_q;
    assign err_chan_o    = err_ch_q;
    assign overrun_o     = ovr_q;

    // R4
    start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |-> (conv_pwr_o && conv_single_o && $past(conv_single_o)
                          && $stable(conv_chan_o)));

    // R4
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |=> !conv_start_o);

    // R8
    power_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_done_o || scan_err_o) |-> !conv_pwr_o);

    // R11
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(scan_done_o && scan_err_o));

    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done_o |=> !scan_done_o);

    // R7
    no_start_after_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_err_o |-> !conv_start_o);

    // R10
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |=> overrun_o);

endmodule

// File: tb/adc_scan_seq_tb.sv
// Self-checking bench: sweeps every scan mask, a spread of reserved masks,
// poll-bound edges, channel faults and trigger collisions.
module adc_scan_seq_tb;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       trig = 1'b0;
    logic [7:0] smask = '0, rmask = '0, gap = '0;
    logic       eoc = 1'b0;
    logic [2:0] smp = '0;
    logic [9:0] cdata = '0;

    logic       pwr, single, start, done, err, ovr;
    logic [2:0] chan, err_ch;
    logic [79:0] rbuf;
    logic [3:0] rcnt;

    adc_scan_seq u_dut (
        .clk(clk), .rst_n(rst_n), .trig_i(trig),
        .scan_mask_i(smask), .rsvd_mask_i(rmask), .poll_gap_i(gap),
        .conv_pwr_o(pwr), .conv_single_o(single), .conv_chan_o(chan),
        .conv_start_o(start), .conv_eoc_i(eoc), .conv_smp_ch_i(smp),
        .conv_data_i(cdata), .scan_done_o(done), .scan_err_o(err),
        .err_chan_o(err_ch), .res_buf_o(rbuf), .res_count_o(rcnt),
        .overrun_o(ovr)
    );

    int checks = 0, fails = 0, cyc = 0;
    int lat = 3, fmode = 0, fch = 0, sdel = 0, scan_id = 0;
    int cnt = 0, scnt = 0;
    logic [2:0] cur = '0;
    int start_log[16];
    int start_n = 0, first_gap = -1, pwr_k = 0;
    logic pwr_prev = 1'b0;
    logic s_done, s_err, s_pwr;
    logic [2:0] s_ech;
    logic [79:0] s_buf, prev_buf = '0;
    logic [3:0] s_cnt, prev_cnt = '0;

    function automatic logic [9:0] fval(input int ch, input int sid);
        return 10'((ch * 97 + sid * 13 + 5) % 1024);
    endfunction

    task automatic chk(input bit ok, input string tag,
                       input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Converter model: fault 1 never ends, 2 reports a wrong channel, 3 late
    always @(negedge clk) begin
        if (pwr) begin
            pwr_k = pwr_prev ? pwr_k + 1 : 0;
            if (start && first_gap < 0) first_gap = pwr_k;
        end
        pwr_prev = pwr;
        if (start) begin
            cur = chan;
            if (start_n < 16) start_log[start_n] = int'(chan);
            start_n++;
            eoc = 1'b0;
            cnt = lat;
            scnt = 0;
        end else if (cnt > 0) begin
            cnt--;
            if (cnt == 0 && !(fmode == 1 && int'(cur) == fch)) begin
                eoc = 1'b1;
                cdata = fval(int'(cur), scan_id);
                if ((fmode == 2 || fmode == 3) && int'(cur) == fch) begin
                    smp = cur ^ 3'd1;
                    scnt = (fmode == 3) ? sdel : 0;
                end else begin
                    smp = cur;
                end
            end
        end else if (scnt > 0) begin
            scnt--;
            if (scnt == 0) smp = cur;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected below 150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    task automatic fire(input logic [7:0] sm, input logic [7:0] rm,
                        input logic [7:0] g, input logic [7:0] alt);
        @(negedge clk);
        smask = sm; rmask = rm; gap = g;
        scan_id++;
        start_n = 0;
        first_gap = -1;
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        smask = alt;
        rmask = ~rm;
    endtask

    task automatic wait_end();
        int n = 0;
        while (!done && !err && n < 4000) begin
            @(negedge clk);
            n++;
        end
        s_done = done; s_err = err; s_pwr = pwr;
        s_ech = err_ch; s_buf = rbuf; s_cnt = rcnt;
    endtask

    task automatic check_end(input logic [7:0] eff, input bit efail, input int ech);
        logic [79:0] ebuf = '0;
        int k = 0;
        bit order_ok = 1'b1;
        bit stop = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (eff[i] && !stop) begin
                if (k >= start_n || k >= 16 || start_log[k] != i) order_ok = 1'b0;
                ebuf[k*10 +: 10] = fval(i, scan_id);
                k++;
                if (efail && i == ech) stop = 1'b1;
            end
        end
        // R2 channel set and ascending order of starts
        chk(order_ok && (start_n == k), "R2 start order", 80'(start_n), 80'(k));
        if (efail) begin
            chk(s_err && !s_done, "R7 error pulse", {s_err, s_done}, 2'b10);
            chk(s_ech == 3'(ech), "R7 failing channel", 80'(s_ech), 80'(ech));
            chk(s_buf == prev_buf && s_cnt == prev_cnt, "R7 results held",
                s_buf, prev_buf);
        end else begin
            chk(s_done && !s_err, "R11 done pulse", {s_err, s_done}, 2'b01);
            chk(s_buf == ebuf, "R3 packed buffer", s_buf, ebuf);
            chk(s_cnt == 4'(k), "R3 entry count", 80'(s_cnt), 80'(k));
            prev_buf = s_buf;
            prev_cnt = s_cnt;
        end
        chk(!s_pwr, "R8 power low at end", 80'(s_pwr), 80'(0));
        if (eff != 8'h00)
            chk(first_gap == 9, "R4 power-up to start", 80'(first_gap), 80'(9));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(!pwr && !single && !start && !done && !err && !ovr && rbuf == '0 && rcnt == '0,
            "R1 reset state", {pwr, single, start, done, err, ovr, rcnt}, '0);
        rst_n = 1'b1;

        // R3 R2: every scan mask, nothing reserved
        for (int m = 0; m < 256; m++) begin
            fire(8'(m), 8'h00, 8'd1, 8'(m));
            wait_end();
            check_end(8'(m), 1'b0, 0);
        end

        // R2: reserved channels removed from a full request
        for (int r = 0; r < 256; r += 9) begin
            fire(8'hFF, 8'(r), 8'd0, 8'hFF);
            wait_end();
            check_end(~8'(r), 1'b0, 0);
        end

        // R2: mask change after the trigger is ignored
        fire(8'h5A, 8'h00, 8'd2, 8'hA5);
        wait_end();
        check_end(8'h5A, 1'b0, 0);

        // R9: empty effective set
        fire(8'h0F, 8'h0F, 8'd1, 8'h0F);
        chk(done && rcnt == '0 && rbuf == '0 && !pwr, "R9 empty scan",
            {done, pwr, rcnt}, {1'b1, 1'b0, 4'd0});
        wait_end();
        check_end(8'h00, 1'b0, 0);
        chk(first_gap < 0, "R9 no power-up", 80'(first_gap), '1);
        @(negedge clk);
        chk(!done && !err, "R11 single-cycle done", {done, err}, 2'b00);

        // R5: end-of-conversion on the last poll passes, one clock later fails
        lat = 61;
        fire(8'h10, 8'h00, 8'd2, 8'h10); wait_end(); check_end(8'h10, 1'b0, 0);
        lat = 62;
        fire(8'h10, 8'h00, 8'd2, 8'h10); wait_end(); check_end(8'h10, 1'b1, 4);
        lat = 21;
        fire(8'h03, 8'h00, 8'd0, 8'h03); wait_end(); check_end(8'h03, 1'b0, 0);
        lat = 22;
        fire(8'h03, 8'h00, 8'd0, 8'h03); wait_end(); check_end(8'h03, 1'b1, 0);
        lat = 3;

        // R6: sampled channel late but within bound, then never right
        fmode = 3; fch = 2; sdel = 5;
        fire(8'hFF, 8'h00, 8'd1, 8'hFF); wait_end(); check_end(8'hFF, 1'b0, 0);
        fmode = 2; fch = 5;
        fire(8'hFF, 8'h00, 8'd1, 8'hFF); wait_end(); check_end(8'hFF, 1'b1, 5);

        // R7: stuck conversion on each channel aborts the scan
        fmode = 1;
        for (int c = 0; c < 8; c++) begin
            fch = c;
            fire(8'hFF, 8'h00, 8'd1, 8'hFF);
            wait_end();
            check_end(8'hFF, 1'b1, c);
            @(negedge clk);
            chk(!done && !err && !pwr, "R11 single-cycle error", {done, err, pwr}, 3'b000);
        end
        fch = 3;
        fire(8'hF7, 8'h00, 8'd1, 8'hF7); wait_end(); check_end(8'hF7, 1'b0, 0);
        fmode = 0;

        // R10: trigger in the done cycle starts a new scan, no overrun
        fire(8'h81, 8'h00, 8'd1, 8'h81);
        wait_end();
        check_end(8'h81, 1'b0, 0);
        smask = 8'h3C; rmask = 8'h00;
        scan_id++; start_n = 0; first_gap = -1;
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        chk(pwr && !ovr, "R10 back-to-back accepted", {pwr, ovr}, 2'b10);
        wait_end();
        check_end(8'h3C, 1'b0, 0);

        // R10: trigger during a scan is dropped and flagged
        fire(8'hFF, 8'h00, 8'd1, 8'hFF);
        repeat (6) @(negedge clk);
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        wait_end();
        check_end(8'hFF, 1'b0, 0);
        chk(ovr, "R10 overrun flag", 80'(ovr), 80'(1));
        @(negedge clk);
        chk(!pwr && ovr, "R10 dropped trigger", {pwr, ovr}, 2'b01);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule